// File: doc/BRIEF.md
# Prime-Stride Modular Sequence Generator

This block emits a pseudo-random walk over the integers 0 to P-1, where the output at step n is (n times S) mod P. S (the stride) and P (the modulus) are primes fixed at elaboration, with S below P. Each output is the previous one plus S, folded back into range with one subtraction of P, so no multiplier or divider is needed. Every value in 0..P-1 appears exactly once per period, and the period is P.

A step counter tracks n. When n returns from P-1 to 0, a one-cycle restart pulse marks the start of a new period. The advance input gates progress. While it is low, the output and the counter hold.

Top module: `modseq_top`

## Requirements
- R1: After a synchronous reset, `seqVal` is 0, the step index is 0 and `restart` is 0.
- R2: On each clock with `advance` high, `seqVal` becomes (old + S) mod P. With S=7 and P=17 the outputs run 0, 7, 14, 4, 11, and so on.
- R3: While `advance` is low, `seqVal` and the step index keep their values and `restart` stays 0.
- R4: `seqVal` is always less than P.
- R5: `restart` is high for exactly the one cycle that follows an advance in which the step index moved from P-1 to 0. It is low at all other times.
- R6: Over P consecutive advances starting from index 0, every value in 0..P-1 appears once, and `seqVal` is 0 again after the P-th advance.
- R7: `seqVal` is 0 whenever `restart` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Step enable |
| seqVal | output | VW | Current sequence value (VW = clog2(P)+1) |
| restart | output | 1 | One-cycle pulse when the period restarts |

## Verification
The assertions assume that `advance` is a clean level sampled at the rising edge and that reset is held for at least one edge before stepping begins. They also assume the parameters satisfy S < P, which the design checks at elaboration. The stimulus changes `advance` only at falling edges, mixing long runs, single steps and idle stretches. It runs more than two full periods, so the restart pulse is seen both on back-to-back advances and after a pause.

// File: rtl/modseq_pkg.sv
package modseq_pkg;
  typedef struct packed {
    logic load0;
    logic step;
  } seqCtl_t;
endpackage

// File: rtl/modseq_ctrl.sv
module modseq_ctrl #(
  parameter int unsigned MODP = 17,
  localparam int unsigned IW = $clog2(MODP) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output modseq_pkg::seqCtl_t ctl,
  output logic restart
);
  logic [IW-1:0] stepIdx;
  logic lastStep;

  assign lastStep  = (stepIdx == IW'(MODP - 1));
  assign ctl.load0 = rst;
  assign ctl.step  = advance & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      stepIdx <= '0;
      restart <= 1'b0;
    end else begin
      restart <= advance & lastStep;
      if (advance) stepIdx <= lastStep ? '0 : stepIdx + 1'b1;
    end
  end

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(stepIdx));
  // R5
  restart_src_chk: assert property (@(posedge clk) disable iff (rst)
    restart |-> stepIdx == '0);
  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    stepIdx < IW'(MODP));
endmodule

// File: rtl/modseq_dp.sv
module modseq_dp #(
  parameter int unsigned STRIDE = 7,
  parameter int unsigned MODP = 17,
  localparam int unsigned VW = $clog2(MODP) + 1
) (
  input  logic clk,
  input  modseq_pkg::seqCtl_t ctl,
  output logic [VW-1:0] seqVal
);
  logic [VW-1:0] rawSum;
  logic [VW-1:0] nextVal;

  assign rawSum  = seqVal + VW'(STRIDE);
  assign nextVal = (rawSum >= VW'(MODP)) ? rawSum - VW'(MODP) : rawSum;

  always_ff @(posedge clk) begin
    if (ctl.load0) seqVal <= '0;
    else if (ctl.step) seqVal <= nextVal;
  end

  // R4
  val_range_chk: assert property (@(posedge clk) disable iff (ctl.load0)
    seqVal < VW'(MODP));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (ctl.load0)
    ctl.step |=> (seqVal == (($past(seqVal) + VW'(STRIDE)) % VW'(MODP))));
endmodule

// File: rtl/modseq_top.sv
module modseq_top #(
  parameter int unsigned STRIDE = 7,
  parameter int unsigned MODP = 17,
  localparam int unsigned VW = $clog2(MODP) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic [VW-1:0] seqVal,
  output logic restart
);
  modseq_pkg::seqCtl_t ctl;

  if (STRIDE >= MODP || STRIDE == 0) begin : g_badParam
    initial $fatal(1, "stride must be in 1..modulus-1");
  end

  modseq_ctrl #(.MODP(MODP)) u_ctrl (
    .clk(clk), .rst(rst), .advance(advance), .ctl(ctl), .restart(restart));

  modseq_dp #(.STRIDE(STRIDE), .MODP(MODP)) u_dp (
    .clk(clk), .ctl(ctl), .seqVal(seqVal));

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart |-> seqVal == '0);
  // R3
  val_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(seqVal) && !restart);
endmodule

// File: tb/modseq_top_tb.sv
module modseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S = 7;
  localparam int P = 17;
  localparam int VW = $clog2(P) + 1;

  logic clk = 0, rst = 1, advance = 0;
  logic [VW-1:0] seqVal;
  logic restart;
  int total = 0, bad = 0;
  int modelK = 0, modelWrap = 0;
  bit live = 0;
  int seen[int];

  always #(CLK_PERIOD/2) clk = ~clk;

  modseq_top #(.STRIDE(S), .MODP(P)) u_dut (
    .clk(clk), .rst(rst), .advance(advance), .seqVal(seqVal), .restart(restart));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // reference model, updated at each posedge from the inputs then held
  always @(posedge clk) begin
    if (rst) begin
      modelK = 0;
      modelWrap = 0;
    end else begin
      modelWrap = (advance && modelK == P-1) ? 1 : 0;
      if (advance) modelK = (modelK + 1) % P;
    end
  end

  // compare every cycle at the falling edge
  always @(negedge clk) if (live) begin
    check("R2/R3", seqVal, (modelK * S) % P);
    check("R5", restart, modelWrap);
    if (restart) check("R7", seqVal, 0);
    check("R4", seqVal < P, 1);
  end

  task automatic steps(int n, bit en);
    for (int i = 0; i < n; i++) begin
      advance = en;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 val", seqVal, 0);
    check("R1 restart", restart, 0);
    live = 1;
    // R2: opening terms 0,7,14,4,11
    advance = 1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R2 seq", seqVal, (i * S) % P);
    end
    // R3 idle stretch
    advance = 0;
    steps(5, 0);
    check("R3 hold", seqVal, (4 * S) % P);
    // R6: complete the period from index 4 to a full P
    for (int i = 0; i < P; i++) begin
      seen[int'(seqVal)] = 1;
      advance = 1;
      @(negedge clk);
      advance = 0;
      if (i == 12) begin
        check("R5 pulse", restart, 1);
        check("R6 back to zero", seqVal, 0);
      end
      if (i == 12) steps(3, 0);
    end
    check("R6 coverage", seen.num(), P);
    // second period, back-to-back, with pulse after a pause done above
    steps(2 * P + 3, 1);
    steps(4, 0);
    // mid-run reset
    advance = 1;
    rst = 1;
    @(negedge clk);
    rst = 0;
    advance = 0;
    check("R1 reset again", seqVal, 0);
    steps(3, 0);
    live = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule